// File: doc/BRIEF.md
# Echo-Timed Variable Pulse Width Symbol Transmitter

This block drives one symbol at a time onto a variable-pulse-width serial bus through an external transceiver. A symbol is either active, where the transmit pin is held high, or passive, where it is held low. The block does not time a symbol from the moment it starts driving. It waits until the filtered receive input shows the bus at the symbol's level, then counts only the part of the nominal width that remains. That part is the nominal width minus the programmed transceiver delay and minus the fixed receive-filter delay. If another node brought the bus to that level first, the count starts from that earlier edge, so this transmitter falls in step with the other node.

Time is counted in ticks of a 1 µs time base supplied as a one-cycle strobe. When the count runs out, the block releases the pin and pulses a done strobe. If the bus never reaches the symbol's level, a timeout releases the pin and flags a fault with the done strobe. A higher layer issues the symbol sequence one request at a time and moves on after each done strobe.

Top module: `vpw_echo_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_out`, `sym_done` and `tx_fault` are all low.
- R2: A request is accepted only while the block is idle and `sym_kind` is 0 to 4. The codes are: 0 start-of-frame (active, 200 µs), 1 short active (64 µs), 2 long active (128 µs), 3 short passive (64 µs), 4 long passive (128 µs). Codes 0 to 2 drive `tx_out` high from the cycle after acceptance. Codes 3 and 4 keep it low.
- R3: Timing begins at the first clock edge after acceptance at which `rx_filt` equals the symbol's level (high for active, low for passive). This also covers a bus that is already at that level when the request arrives. Ticks before that edge do not count toward the symbol width.
- R4: After the start edge, the symbol ends at the clock edge that samples the N-th further tick, where N = nominal width − `xcvr_dly` − 8 (for example 200 − 14 − 8 = 178).
- R5: `sym_done` is a single-cycle pulse. In that cycle `tx_out` is already low.
- R6: If 64 ticks are sampled while waiting for the bus level, the symbol is abandoned. `sym_done` and `tx_fault` pulse together and `tx_out` goes low.
- R7: A request raised while a symbol is in progress is ignored. It starts no further symbol after the current one ends.
- R8: A request with `sym_kind` 5, 6 or 7 is ignored. `tx_out` stays low and no `sym_done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| sym_req | input | 1 | Symbol request, sampled while idle |
| sym_kind | input | 3 | Symbol code (see R2) |
| xcvr_dly | input | 5 | External transceiver delay in µs |
| rx_filt | input | 1 | Filtered receive level of the bus |
| tx_out | output | 1 | Transmit pin to the transceiver |
| sym_done | output | 1 | One-cycle strobe when the symbol ends |
| tx_fault | output | 1 | One-cycle strobe with `sym_done` on echo timeout |

## Verification
The bench targets the moment timing begins. It raises the echo only after an arbitrary number of ticks, it presents a bus already active before the request (resynchronisation), and it holds the bus active for a while before a passive symbol. A design that counted from its own drive edge would end these symbols early by exactly the echo latency. Delay settings of 0, 14, 20 and 31 show whether the compensation is subtracted correctly; an off-by-one in the tick counter shows up as a width one tick off. Missing echoes on both an active and a passive symbol test the 64-tick timeout. A request poked in mid-symbol and an out-of-range code would each produce an unexpected extra symbol in a design that failed to ignore them.

// File: rtl/vpw_pkg.sv
// Shared symbol codes and state encoding for the echo-timed transmitter.
// Assumes a 3-bit symbol code; codes above SYM_PAS_LONG are invalid.
package vpw_pkg;

    typedef enum logic [2:0] {
        SYM_SOF       = 3'd0,
        SYM_ACT_SHORT = 3'd1,
        SYM_ACT_LONG  = 3'd2,
        SYM_PAS_SHORT = 3'd3,
        SYM_PAS_LONG  = 3'd4
    } sym_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } tx_state_e;

    // True for a code the block will transmit.
    function automatic logic kind_valid(input logic [2:0] k);
        return k <= 3'(SYM_PAS_LONG);
    endfunction

    // True for a code that drives the bus active.
    function automatic logic kind_active(input logic [2:0] k);
        return k <= 3'(SYM_ACT_LONG);
    endfunction

endpackage

// File: rtl/vpw_sym_dur.sv
// Compensated symbol duration: nominal width minus transceiver delay
// minus the receive-filter delay, in ticks. Assumes widths fit CNT_W;
// a result below one is raised to one so a symbol always lasts a tick.
module vpw_sym_dur
    import vpw_pkg::*;
#(
    parameter int SOF_US   = 200,
    parameter int SHORT_US = 64,
    parameter int LONG_US  = 128,
    parameter int FILT_US  = 8,
    parameter int DLY_W    = 5,
    parameter int CNT_W    = 8
) (
    input  logic [2:0]       kind,
    input  logic [DLY_W-1:0] dly,
    output logic [CNT_W-1:0] run_ticks
);

    int nom_i;
    int comp_i;

    // Pick the nominal width and subtract both delays.
    always_comb begin
        case (kind)
            3'(SYM_SOF):                    nom_i = SOF_US;
            3'(SYM_ACT_LONG), 3'(SYM_PAS_LONG): nom_i = LONG_US;
            default:                        nom_i = SHORT_US;
        endcase
        comp_i = nom_i - int'(dly) - FILT_US;
        if (comp_i < 1) begin
            comp_i = 1;
        end
        run_ticks = CNT_W'(comp_i);
    end

endmodule

// File: rtl/vpw_tick_counter.sv
// Loadable down-counter stepped by the microsecond tick while enabled.
// Assumes a load value of at least one; 'last' marks the final tick.
module vpw_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    input  logic         tick,
    output logic         last
);

    logic [W-1:0] count;

    // Load on request, otherwise count down on enabled ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (en && tick && count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign last = en && tick && (count == W'(1));

endmodule

// File: rtl/vpw_tx_fsm.sv
// Symbol sequencer: accepts a request while idle, drives the pin, waits
// for the echoed level, then runs the compensated count to release.
// Assumes counters are loaded on 'load' and report their final tick.
module vpw_tx_fsm
    import vpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_req,
    input  logic [2:0] sym_kind,
    input  logic       rx_filt,
    input  logic       run_last,
    input  logic       wait_last,
    output logic       load,
    output logic       run_en,
    output logic       wait_en,
    output logic       busy,
    output logic       tx_out,
    output logic       sym_done,
    output logic       tx_fault
);

    tx_state_e state;
    logic      lvl;
    logic      accept;
    logic      echo;

    // Decode acceptance, echo detection and counter enables.
    always_comb begin
        accept  = (state == ST_IDLE) && sym_req && kind_valid(sym_kind);
        echo    = (state == ST_WAIT) && (rx_filt == lvl);
        load    = accept;
        wait_en = (state == ST_WAIT) && !echo;
        run_en  = (state == ST_RUN);
        busy    = (state != ST_IDLE);
    end

    // Advance the symbol and drive the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lvl      <= 1'b0;
            tx_out   <= 1'b0;
            sym_done <= 1'b0;
            tx_fault <= 1'b0;
        end else begin
            sym_done <= 1'b0;
            tx_fault <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state  <= ST_WAIT;
                        lvl    <= kind_active(sym_kind);
                        tx_out <= kind_active(sym_kind);
                    end
                end
                ST_WAIT: begin
                    if (echo) begin
                        state <= ST_RUN;
                    end else if (wait_last) begin
                        state    <= ST_IDLE;
                        tx_out   <= 1'b0;
                        sym_done <= 1'b1;
                        tx_fault <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (run_last) begin
                        state    <= ST_IDLE;
                        tx_out   <= 1'b0;
                        sym_done <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vpw_echo_tx.sv
// Top: echo-timed variable pulse width symbol transmitter. Symbol width
// is counted from the receiver's view of the bus edge, less transceiver
// and filter delay. Assumes tick_us is a one-cycle strobe per µs.
module vpw_echo_tx #(
    parameter int SOF_US          = 200,
    parameter int SHORT_US        = 64,
    parameter int LONG_US         = 128,
    parameter int FILT_US         = 8,
    parameter int ECHO_TIMEOUT_US = 64,
    parameter int DLY_W           = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_us,
    input  logic             sym_req,
    input  logic [2:0]       sym_kind,
    input  logic [DLY_W-1:0] xcvr_dly,
    input  logic             rx_filt,
    output logic             tx_out,
    output logic             sym_done,
    output logic             tx_fault
);

    localparam int MAX_US = (SOF_US > LONG_US) ? SOF_US : LONG_US;
    localparam int CNT_W  = $clog2(MAX_US + 1);
    localparam int TMO_W  = $clog2(ECHO_TIMEOUT_US + 1);

    logic [CNT_W-1:0] run_ticks;
    logic             load;
    logic             run_en;
    logic             wait_en;
    logic             run_last;
    logic             wait_last;
    logic             busy;

    vpw_sym_dur #(
        .SOF_US   (SOF_US),
        .SHORT_US (SHORT_US),
        .LONG_US  (LONG_US),
        .FILT_US  (FILT_US),
        .DLY_W    (DLY_W),
        .CNT_W    (CNT_W)
    ) u_dur (
        .kind      (sym_kind),
        .dly       (xcvr_dly),
        .run_ticks (run_ticks)
    );

    vpw_tick_counter #(.W(CNT_W)) u_run_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (run_ticks),
        .en       (run_en),
        .tick     (tick_us),
        .last     (run_last)
    );

    vpw_tick_counter #(.W(TMO_W)) u_wait_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (TMO_W'(ECHO_TIMEOUT_US)),
        .en       (wait_en),
        .tick     (tick_us),
        .last     (wait_last)
    );

    vpw_tx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_req   (sym_req),
        .sym_kind  (sym_kind),
        .rx_filt   (rx_filt),
        .run_last  (run_last),
        .wait_last (wait_last),
        .load      (load),
        .run_en    (run_en),
        .wait_en   (wait_en),
        .busy      (busy),
        .tx_out    (tx_out),
        .sym_done  (sym_done),
        .tx_fault  (tx_fault)
    );

endmodule

// File: rtl/vpw_echo_tx_chk.sv
// Protocol checker for vpw_echo_tx, attached with bind below.
// Assumes 'busy' is the top's internal not-idle indication.
module vpw_echo_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_req,
    input logic [2:0] sym_kind,
    input logic       busy,
    input logic       tx_out,
    input logic       sym_done,
    input logic       tx_fault
);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_done |=> !sym_done);

    // R5
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_done |-> !tx_out);

    // R6
    fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fault |-> sym_done);

    // R2
    active_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sym_req && sym_kind <= 3'd2) |=> (tx_out && busy));

    // R2
    passive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sym_req && (sym_kind == 3'd3 || sym_kind == 3'd4)) |=> (!tx_out && busy));

    // R8
    bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sym_req && sym_kind > 3'd4) |=> (!busy && !tx_out));

    // R7
    rise_needs_idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_out) |-> $past(sym_req && !busy));

endmodule

bind vpw_echo_tx vpw_echo_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_req  (sym_req),
    .sym_kind (sym_kind),
    .busy     (busy),
    .tx_out   (tx_out),
    .sym_done (sym_done),
    .tx_fault (tx_fault)
);

// File: tb/vpw_echo_tx_test.sv
// Scoreboard bench: the driver queues the expected outcome of each symbol,
// the monitor counts ticks from the echo edge and compares at sym_done.
module vpw_echo_tx_test;

    typedef struct {
        logic  lvl;
        logic  fault;
        int    ticks;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b0;
    logic       sym_req = 1'b0;
    logic [2:0] sym_kind = 3'd0;
    logic [4:0] xcvr_dly = 5'd14;
    logic       rx_filt = 1'b0;
    logic       tx_out;
    logic       sym_done;
    logic       tx_fault;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   armed = 1'b0;
    bit   ended = 1'b0;
    exp_t expq[$];

    always #2 clk = ~clk;

    vpw_echo_tx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_us  (tick_us),
        .sym_req  (sym_req),
        .sym_kind (sym_kind),
        .xcvr_dly (xcvr_dly),
        .rx_filt  (rx_filt),
        .tx_out   (tx_out),
        .sym_done (sym_done),
        .tx_fault (tx_fault)
    );

    // Time base: one-cycle tick every fourth clock.
    initial begin
        int div = 0;
        forever begin
            @(posedge clk);
            #1;
            div     = (div + 1) % 4;
            tick_us = (div == 0);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: counts sampled ticks and compares each finished symbol.
    initial begin
        bit   matched = 1'b0;
        int   wcnt = 0;
        int   rcnt = 0;
        bit   tx_bad = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (sym_done) begin
                if (expq.size() == 0) begin
                    check("R7/R8 unexpected sym_done", 1, 0);
                end else begin
                    e = expq.pop_front();
                    check({e.req, " fault"}, int'(tx_fault), int'(e.fault));
                    check({e.req, " ticks"}, e.fault ? wcnt : rcnt, e.ticks);
                    check({e.req, " R5 tx low at done"}, int'(tx_out), 0);
                    check({e.req, " R2 level held"}, int'(tx_bad), 0);
                end
                armed   = 1'b0;
                matched = 1'b0;
                wcnt    = 0;
                rcnt    = 0;
                tx_bad  = 1'b0;
                @(negedge clk);
                check("R5 done single cycle", int'(sym_done), 0);
            end
            if (armed) begin
                if (expq.size() != 0 && tx_out != expq[0].lvl) tx_bad = 1'b1;
                if (!matched) begin
                    if (expq.size() != 0 && rx_filt == expq[0].lvl) matched = 1'b1;
                    else if (tick_us) wcnt++;
                end else if (tick_us) begin
                    rcnt++;
                end
            end
        end
    end

    // Driver: issue one symbol, model the echo, wait for completion.
    task automatic send(input string req, input logic [2:0] kind, input logic [4:0] dly,
                        input logic pre, input int echo_after, input int nom,
                        input bit poke);
        exp_t e;
        logic lvl = (kind <= 3'd2);
        e.lvl   = lvl;
        e.fault = (echo_after < 0);
        e.ticks = (echo_after < 0) ? 64 : nom - int'(dly) - 8;
        e.req   = req;
        @(posedge clk);
        #1;
        xcvr_dly = dly;
        rx_filt  = pre;
        sym_kind = kind;
        sym_req  = 1'b1;
        expq.push_back(e);
        @(posedge clk);
        #1;
        sym_req = 1'b0;
        armed   = 1'b1;
        if (echo_after >= 0) begin
            int k = 0;
            while (k < echo_after) begin
                @(posedge clk);
                if (tick_us) k++;
            end
            #1;
            rx_filt = lvl;
        end
        if (poke) begin
            repeat (20) @(posedge clk);
            #1;
            sym_kind = 3'd0;
            sym_req  = 1'b1;
            @(posedge clk);
            #1;
            sym_req = 1'b0;
        end
        do @(negedge clk); while (!sym_done);
        @(posedge clk);
        #1;
        rx_filt = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 tx_out in reset", int'(tx_out), 0);
        check("R1 sym_done in reset", int'(sym_done), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 tx_fault after reset", int'(tx_fault), 0);
        check("R1 tx_out after reset", int'(tx_out), 0);

        // R4 SOF with delay 14: 178 ticks after echo
        send("R4 SOF dly14", 3'd0, 5'd14, 1'b0, 22, 200, 1'b0);
        // R2 short active, delay 0
        send("R2 short active dly0", 3'd1, 5'd0, 1'b0, 3, 64, 1'b0);
        // R2 long active, delay 20
        send("R2 long active dly20", 3'd2, 5'd20, 1'b0, 9, 128, 1'b0);
        // R4 largest delay
        send("R4 short active dly31", 3'd1, 5'd31, 1'b0, 40, 64, 1'b0);
        // R3 bus already active before request: resynchronise
        send("R3 SOF resync", 3'd0, 5'd14, 1'b1, 0, 200, 1'b0);
        // R2 short passive with bus already released
        send("R2 short passive", 3'd3, 5'd14, 1'b0, 0, 64, 1'b0);
        // R3 long passive, another node holds bus 10 ticks
        send("R3 long passive late release", 3'd4, 5'd14, 1'b1, 10, 128, 1'b0);
        // R6 active echo never arrives
        send("R6 active no echo", 3'd1, 5'd14, 1'b0, -1, 64, 1'b0);
        // R6 passive, bus stuck active
        send("R6 passive stuck bus", 3'd3, 5'd14, 1'b1, -1, 64, 1'b0);
        // R7 request poked mid-symbol
        send("R7 busy poke", 3'd2, 5'd14, 1'b0, 5, 128, 1'b1);
        repeat (400) @(posedge clk);
        #1;
        check("R7 no symbol after poke", int'(tx_out), 0);

        // R8 invalid code ignored
        @(posedge clk);
        #1;
        sym_kind = 3'd6;
        sym_req  = 1'b1;
        @(posedge clk);
        #1;
        sym_req = 1'b0;
        @(negedge clk);
        check("R8 invalid code tx_out", int'(tx_out), 0);
        repeat (300) @(posedge clk);
        #1;
        check("R8 invalid code no activity", int'(tx_out), 0);

        repeat (4) @(posedge clk);
        check("R2 scoreboard drained", expq.size(), 0);
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule